// File: doc/BRIEF.md
# Processor Idle-State Tracking Controller

This block lives on the memory-controller side of a processor link and keeps a copy of the core's idle state. It builds that copy from the bus cycles the core issues. From the tracked state it decides, for each memory requester, whether the request may proceed now. Requests that carry no coherency snoop always proceed. Requests that need a snoop proceed only while the core can answer snoops.

Once the core has entered deep sleep it can no longer answer snoops. The controller then holds every snoop-requiring request and lets snoop-free traffic keep flowing. A break event or a held snoop request starts a wake handshake. The controller raises a wake request and holds it until the core acknowledges that it is ready. When the handshake completes, the held snoop requests are released one per clock in the order they arrived.

Requesters hold their valid and snoop flags until they see a grant. A grant or a stall is combinational in the same cycle as the request. The tracked state is registered and changes on the clock edge after the cycle that causes it.

Top module: `idle_state_ctrl`

## Requirements
- R1: After the active-low asynchronous reset is released, `state_o` is 00 (fully on) and `wake_req_o` is 0. With no request valid, no grant, stall or stop-grant acknowledge is driven.
- R2: `state_o` uses these codes: 00 fully on, 01 stop grant, 10 deep sleep, 11 waking. The cycle-type codes are 000 none, 001 halt, 010 enhanced halt, 011 stop grant, 100 enhanced stop grant, 101 deep-sleep request, and 110/111 reserved. A halt cycle (001) in fully on leaves the state at 00, and snoop requests are still granted. Codes 000, 110 and 111 never change the state.
- R3: An enhanced halt (010) behaves exactly like a halt (001), and an enhanced stop grant (100) behaves exactly like a stop grant (011).
- R4: A stop-grant cycle in fully on pulses `stpgnt_ack_o` in that cycle, and the state becomes 01 on the next edge. In state 01, snoop requests are granted and `wake_req_o` stays 0.
- R5: A stop-grant cycle received in state 01 is not accepted. `stpgnt_ack_o` stays 0 and the state stays 01.
- R6: A break event in state 01 returns the state to 00. A break event in the same cycle as a stop-grant or deep-sleep cycle in state 00 wins. No acknowledge is given and the state stays 00.
- R7: A deep-sleep request (101) in state 00 or 01, without a break, moves the state to 10 on the next edge. In states 10 and 11 it is ignored.
- R8: In every state, a valid request with the snoop flag clear is granted in the same cycle and never stalled.
- R9: In states 10 and 11, a valid snoop request is stalled, not granted. In state 10, a break event or any valid snoop request moves the state to 11, and `wake_req_o` is then 1.
- R10: In state 11, `wake_req_o` stays 1 and the state stays 11 until `core_ready_i` is seen. The next edge then gives state 00 with `wake_req_o` at 0. `core_ready_i` has no effect in any other state.
- R11: Stalled snoop requests are granted after the wake, one per cycle, in arrival order. Requests that first stall in the same cycle are ordered by ascending requester index. Until the held requests have all been released, any other snoop request is stalled. A requester never sees grant and stall together, and only a valid snoop request is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_type_i | input | 3 | Decoded core cycle type for this clock |
| break_i | input | 1 | Break event |
| core_ready_i | input | 1 | Core acknowledges the wake |
| req_valid_i | input | N_REQ | Memory request valid, one bit per requester |
| req_snoop_i | input | N_REQ | Request needs a coherency snoop |
| state_o | output | 2 | Tracked idle-state code |
| stpgnt_ack_o | output | 1 | Stop-grant cycle accepted this clock |
| req_grant_o | output | N_REQ | Request may proceed this clock |
| req_stall_o | output | N_REQ | Snoop request held this clock |
| wake_req_o | output | 1 | Wake request to the core |

## Verification
The bench builds the block with N_REQ = 4. That is small enough to sweep every combination of valid and snoop flags in each state where snoops may proceed. The control sweep starts from each of the four tracked states and covers every cycle code, with break and ready both on and off. A directed run with four requesters holds snoops over several cycles, including two that arrive together. It brings the release ordering and the waking hold within reach.

// File: rtl/idle_pkg.sv
package idle_pkg;
  typedef enum logic [1:0] {
    ST_ON   = 2'b00,
    ST_SG   = 2'b01,
    ST_DEEP = 2'b10,
    ST_WAKE = 2'b11
  } idle_st_e;

  typedef enum logic [2:0] {
    CYC_NONE   = 3'b000,
    CYC_HALT   = 3'b001,
    CYC_HALT_E = 3'b010,
    CYC_SG     = 3'b011,
    CYC_SG_E   = 3'b100,
    CYC_DEEP   = 3'b101,
    CYC_RSV6   = 3'b110,
    CYC_RSV7   = 3'b111
  } cyc_e;
endpackage

// File: rtl/idle_cyc_decode.sv
module idle_cyc_decode
  import idle_pkg::*;
(
  input  logic [2:0] cyc_type_i,
  output logic       sg_o,
  output logic       deep_o
);
  always_comb begin
    sg_o   = 1'b0;
    deep_o = 1'b0;
    case (cyc_e'(cyc_type_i))
      CYC_SG, CYC_SG_E:     sg_o   = 1'b1;
      CYC_DEEP:             deep_o = 1'b1;
      CYC_HALT, CYC_HALT_E: ;  // halt is invisible here
      default:              ;
    endcase
  end
endmodule

// File: rtl/idle_state_fsm.sv
module idle_state_fsm
  import idle_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sg_i,
  input  logic     deep_i,
  input  logic     brk_i,
  input  logic     snp_wake_i,
  input  logic     ready_i,
  output idle_st_e state_o,
  output logic     sg_ack_o
);
  idle_st_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    sg_ack_o = 1'b0;
    case (st_q)
      ST_ON: begin
        if (!brk_i) begin
          if (deep_i) st_d = ST_DEEP;
          else if (sg_i) begin
            st_d     = ST_SG;
            sg_ack_o = 1'b1;
          end
        end
      end
      ST_SG: begin
        if (brk_i)       st_d = ST_ON;
        else if (deep_i) st_d = ST_DEEP;
      end
      ST_DEEP: if (brk_i || snp_wake_i) st_d = ST_WAKE;
      ST_WAKE: if (ready_i) st_d = ST_ON;
      default: st_d = ST_ON;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_ON;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/idle_snoop_queue.sv
module idle_snoop_queue #(
  parameter int N_REQ = 4,
  localparam int IDW = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int CW  = $clog2(N_REQ + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] push_i,
  input  logic             pop_i,
  output logic [IDW-1:0]   head_o,
  output logic             empty_o,
  output logic [N_REQ-1:0] queued_o
);
  logic [IDW-1:0]   mem_q [N_REQ];
  logic [IDW-1:0]   mem_d [N_REQ];
  logic [IDW-1:0]   rd_q, wr_q;
  logic [CW-1:0]    cnt_q;
  logic [N_REQ-1:0] queued_q;
  int               ofs;

  function automatic logic [IDW-1:0] wrap_add(input logic [IDW-1:0] a, input int b);
    int s;
    s = int'(a) + b;
    if (s >= N_REQ) s = s - N_REQ;
    return IDW'(s);
  endfunction

  // same-cycle pushes land in ascending requester order
  always_comb begin
    ofs = 0;
    for (int k = 0; k < N_REQ; k++) mem_d[k] = mem_q[k];
    for (int i = 0; i < N_REQ; i++) begin
      if (push_i[i]) begin
        mem_d[wrap_add(wr_q, ofs)] = IDW'(i);
        ofs = ofs + 1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_REQ; k++) mem_q[k] <= '0;
      rd_q     <= '0;
      wr_q     <= '0;
      cnt_q    <= '0;
      queued_q <= '0;
    end else begin
      for (int k = 0; k < N_REQ; k++) mem_q[k] <= mem_d[k];
      wr_q  <= wrap_add(wr_q, ofs);
      cnt_q <= cnt_q + CW'(ofs) - CW'(pop_i);
      if (pop_i) rd_q <= wrap_add(rd_q, 1);
      queued_q <= (queued_q | push_i)
                  & ~(pop_i ? (N_REQ'(1) << head_o) : '0);
    end
  end

  assign head_o   = mem_q[rd_q];
  assign empty_o  = (cnt_q == '0);
  assign queued_o = queued_q;
endmodule

// File: rtl/idle_state_ctrl.sv
module idle_state_ctrl
  import idle_pkg::*;
#(
  parameter int N_REQ = 4,
  localparam int IDW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       cyc_type_i,
  input  logic             break_i,
  input  logic             core_ready_i,
  input  logic [N_REQ-1:0] req_valid_i,
  input  logic [N_REQ-1:0] req_snoop_i,
  output logic [1:0]       state_o,
  output logic             stpgnt_ack_o,
  output logic [N_REQ-1:0] req_grant_o,
  output logic [N_REQ-1:0] req_stall_o,
  output logic             wake_req_o
);
  logic             sg, deep, snp_ok, q_empty, q_pop;
  logic [IDW-1:0]   q_head;
  logic [N_REQ-1:0] q_queued, q_push, snp_req, grant, stall;
  idle_st_e         st;

  idle_cyc_decode u_dec (
    .cyc_type_i (cyc_type_i),
    .sg_o       (sg),
    .deep_o     (deep)
  );

  assign snp_req = req_valid_i & req_snoop_i;

  idle_state_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sg_i       (sg),
    .deep_i     (deep),
    .brk_i      (break_i),
    .snp_wake_i (|snp_req),
    .ready_i    (core_ready_i),
    .state_o    (st),
    .sg_ack_o   (stpgnt_ack_o)
  );

  assign snp_ok = (st == ST_ON) || (st == ST_SG);

  for (genvar i = 0; i < N_REQ; i++) begin : g_req
    // held requests drain from the queue head first
    assign grant[i] = (req_valid_i[i] & ~req_snoop_i[i])
                    | (snp_req[i] & snp_ok & (q_empty | (q_head == IDW'(i))));
    assign stall[i] = snp_req[i] & ~grant[i];
  end

  assign q_push = stall & ~q_queued;
  assign q_pop  = ~q_empty & grant[q_head];

  idle_snoop_queue #(.N_REQ(N_REQ)) u_q (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (q_push),
    .pop_i    (q_pop),
    .head_o   (q_head),
    .empty_o  (q_empty),
    .queued_o (q_queued)
  );

  assign state_o     = st;
  assign req_grant_o = grant;
  assign req_stall_o = stall;
  assign wake_req_o  = (st == ST_WAKE);
endmodule

// File: rtl/idle_state_ctrl_chk.sv
module idle_state_ctrl_chk #(
  parameter int N_REQ = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       cyc_type_i,
  input logic             break_i,
  input logic             core_ready_i,
  input logic [N_REQ-1:0] req_valid_i,
  input logic [N_REQ-1:0] req_snoop_i,
  input logic [1:0]       state_o,
  input logic             stpgnt_ack_o,
  input logic [N_REQ-1:0] req_grant_o,
  input logic [N_REQ-1:0] req_stall_o,
  input logic             wake_req_o
);
  logic is_halt, is_sg, is_deep;
  assign is_halt = (cyc_type_i == 3'b001) || (cyc_type_i == 3'b010);
  assign is_sg   = (cyc_type_i == 3'b011) || (cyc_type_i == 3'b100);
  assign is_deep = (cyc_type_i == 3'b101);

  AST_HALT_KEEPS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b00 && is_halt) |=> state_o == 2'b00);  // R2
  AST_SG_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b00 && is_sg && !break_i) |=> state_o == 2'b01);  // R4
  AST_SG_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b01 |-> !stpgnt_ack_o);  // R5
  AST_BREAK_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_i |-> !stpgnt_ack_o);  // R6
  AST_SG_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b01 && break_i) |=> state_o == 2'b00);  // R6
  AST_DEEP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!state_o[1] && is_deep && !break_i) |=> state_o == 2'b10);  // R7
  AST_PLAIN_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i & ~req_snoop_i & ~req_grant_o) == '0);  // R8
  AST_SNOOP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[1] |-> (req_grant_o & req_valid_i & req_snoop_i) == '0);  // R9
  AST_DEEP_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b10 && (break_i || |(req_valid_i & req_snoop_i)))
    |=> (state_o == 2'b11 && wake_req_o));  // R9
  AST_WAKE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b11 && !core_ready_i) |=> (state_o == 2'b11 && wake_req_o));  // R10
  AST_WAKE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b11 && core_ready_i) |=> (state_o == 2'b00 && !wake_req_o));  // R10
  AST_GRANT_STALL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_grant_o & req_stall_o) == '0);  // R11
  AST_STALL_SNOOP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_stall_o & ~(req_valid_i & req_snoop_i)) == '0);  // R11
endmodule

bind idle_state_ctrl idle_state_ctrl_chk #(.N_REQ(N_REQ)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cyc_type_i   (cyc_type_i),
  .break_i      (break_i),
  .core_ready_i (core_ready_i),
  .req_valid_i  (req_valid_i),
  .req_snoop_i  (req_snoop_i),
  .state_o      (state_o),
  .stpgnt_ack_o (stpgnt_ack_o),
  .req_grant_o  (req_grant_o),
  .req_stall_o  (req_stall_o),
  .wake_req_o   (wake_req_o)
);

// File: tb/idle_state_ctrl_tb_top.sv
module idle_state_ctrl_tb_top;
  localparam int N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   cyc_type_i = '0;
  logic         break_i = 1'b0;
  logic         core_ready_i = 1'b0;
  logic [N-1:0] req_valid_i = '0;
  logic [N-1:0] req_snoop_i = '0;
  logic [1:0]   state_o;
  logic         stpgnt_ack_o;
  logic [N-1:0] req_grant_o;
  logic [N-1:0] req_stall_o;
  logic         wake_req_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  idle_state_ctrl #(.N_REQ(N)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cyc_type_i   (cyc_type_i),
    .break_i      (break_i),
    .core_ready_i (core_ready_i),
    .req_valid_i  (req_valid_i),
    .req_snoop_i  (req_snoop_i),
    .state_o      (state_o),
    .stpgnt_ack_o (stpgnt_ack_o),
    .req_grant_o  (req_grant_o),
    .req_stall_o  (req_stall_o),
    .wake_req_o   (wake_req_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // set inputs after the falling edge, leave time for combinational settle
  task automatic apply(input logic [2:0] c, input logic b, input logic r,
                       input logic [N-1:0] v, input logic [N-1:0] s);
    @(negedge clk_i);
    cyc_type_i = c; break_i = b; core_ready_i = r;
    req_valid_i = v; req_snoop_i = s;
    #1;
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle_step(input logic [2:0] c, input logic b, input logic r);
    apply(c, b, r, '0, '0);
    tick();
  endtask

  task automatic goto_state(input int s);
    idle_step(3'd0, 1'b1, 1'b0);
    idle_step(3'd0, 1'b0, 1'b1);
    case (s)
      1: idle_step(3'd3, 1'b0, 1'b0);
      2: idle_step(3'd5, 1'b0, 1'b0);
      3: begin idle_step(3'd5, 1'b0, 1'b0); idle_step(3'd0, 1'b1, 1'b0); end
      default: ;
    endcase
  endtask

  function automatic int ref_next(input int s, input int c, input bit b, input bit r);
    bit sgc = (c == 3) || (c == 4);
    bit dpc = (c == 5);
    case (s)
      0: return b ? 0 : (dpc ? 2 : (sgc ? 1 : 0));
      1: return b ? 0 : (dpc ? 2 : 1);
      2: return b ? 3 : 2;
      default: return r ? 0 : 3;
    endcase
  endfunction

  function automatic string ref_tag(input int s, input int c, input bit b);
    case (s)
      0: begin
        if (b) return "R6";
        if (c == 2 || c == 4) return "R3";
        if (c == 3) return "R4";
        if (c == 5) return "R7";
        return "R2";
      end
      1: begin
        if (b) return "R6";
        if (c == 3 || c == 4) return "R5";
        if (c == 5) return "R7";
        return "R4";
      end
      2: return b ? "R9" : "R7";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #(2_000_000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    int order [N];

    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 state in reset", int'(state_o), 0);
    chk("R1 wake in reset", int'(wake_req_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    chk("R1 state after reset", int'(state_o), 0);
    chk("R1 wake after reset", int'(wake_req_o), 0);
    chk("R1 grant idle", int'(req_grant_o), 0);
    chk("R1 stall idle", int'(req_stall_o), 0);
    chk("R1 ack idle", int'(stpgnt_ack_o), 0);

    // control sweep: every start state, cycle code, break, ready
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 8; c++) begin
        for (int b = 0; b < 2; b++) begin
          for (int r = 0; r < 2; r++) begin
            int nx;
            bit ack;
            goto_state(s);
            chk("sweep start state", int'(state_o), s);
            nx  = ref_next(s, c, b[0], r[0]);
            ack = (s == 0) && (c == 3 || c == 4) && !b[0];
            apply(3'(c), b[0], r[0], '0, '0);
            chk({ref_tag(s, c, b[0]), " ack"}, int'(stpgnt_ack_o), int'(ack));
            tick();
            chk({ref_tag(s, c, b[0]), " next state"}, int'(state_o), nx);
            chk({ref_tag(s, c, b[0]), " wake"}, int'(wake_req_o), int'(nx == 3));
          end
        end
      end
    end

    // request sweep where snoops may proceed
    for (int s = 0; s < 2; s++) begin
      goto_state(s);
      for (int vv = 0; vv < 16; vv++) begin
        for (int ss = 0; ss < 16; ss++) begin
          apply(3'd0, 1'b0, 1'b0, N'(vv), N'(ss));
          chk(s == 0 ? "R2 grant in on" : "R4 grant in stop grant",
              int'(req_grant_o), vv);
          chk("R8 no stall", int'(req_stall_o), 0);
          chk("R4 no wake", int'(wake_req_o), 0);
        end
      end
      tick();
      chk("R4 state unchanged by requests", int'(state_o), s);
    end

    // plain traffic in deep sleep and waking
    for (int s = 2; s < 4; s++) begin
      goto_state(s);
      for (int vv = 0; vv < 16; vv++) begin
        apply(3'd0, 1'b0, 1'b0, N'(vv), '0);
        chk("R8 plain grant when asleep", int'(req_grant_o), vv);
        chk("R8 plain no stall", int'(req_stall_o), 0);
      end
      tick();
      chk("R8 plain traffic keeps state", int'(state_o), s);
    end

    // held snoops and release order
    goto_state(2);
    apply(3'd0, 1'b0, 1'b0, 4'b0110, 4'b0100);
    chk("R8 plain grant beside stalled snoop", int'(req_grant_o), 4'b0010);
    chk("R9 snoop stalled in deep", int'(req_stall_o), 4'b0100);
    tick();
    chk("R9 snoop starts wake", int'(state_o), 3);
    chk("R9 wake asserted", int'(wake_req_o), 1);
    apply(3'd0, 1'b0, 1'b0, 4'b1101, 4'b1101);
    chk("R9 stall while waking", int'(req_stall_o), 4'b1101);
    chk("R9 no snoop grant while waking", int'(req_grant_o), 0);
    tick();
    apply(3'd5, 1'b0, 1'b0, 4'b1111, 4'b1111);
    chk("R9 stall all", int'(req_stall_o), 4'b1111);
    tick();
    chk("R7 deep ignored while waking", int'(state_o), 3);
    chk("R10 wake held", int'(wake_req_o), 1);
    apply(3'd0, 1'b0, 1'b1, 4'b1111, 4'b1111);
    chk("R10 stall until ready taken", int'(req_stall_o), 4'b1111);
    tick();
    chk("R10 state on after ready", int'(state_o), 0);
    chk("R10 wake dropped", int'(wake_req_o), 0);

    order = '{2, 0, 3, 1};
    v = 4'b1111;
    for (int k = 0; k < N; k++) begin
      apply(3'd0, 1'b0, 1'b0, v, v);
      chk("R11 release order", int'(req_grant_o), 1 << order[k]);
      chk("R11 others held", int'(req_stall_o), int'(v & ~(N'(1) << order[k])));
      tick();
      v[order[k]] = 1'b0;
    end
    apply(3'd0, 1'b0, 1'b0, 4'b1010, 4'b1010);
    chk("R11 queue drained, direct grant", int'(req_grant_o), 4'b1010);
    tick();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule